// File: doc/BRIEF.md
# Permission-Checking Page Table Walker

This block turns a virtual address into a physical address by reading page table entries from memory, one level at a time. A requester hands it a virtual address together with the kind of access (instruction fetch, data load or data store), whether the effective privilege is supervisor or user, two control bits that change how leaf permissions are judged, and the page number of the root table. The walker then issues entry reads on a single request/response memory port and follows pointer entries downward until it reaches a leaf or a fault.

At a leaf it runs an ordered chain of permission checks. First comes user/supervisor ownership, where the supervisor-user-block bit keeps supervisor code off user pages. Next comes the write-without-read encoding, which is reserved. Last comes the rule for the access type, where the make-executable-readable bit lets loads read execute-only pages. A leaf that passes has its accessed flag set in memory, and on a store its dirty flag too. That write is only issued when a flag is actually missing. A leaf found above the bottom level maps a large page, and the low page-number bits then come from the virtual address.

Only one walk is in flight at a time. The result is a single-cycle response carrying either the physical address or a fault flag.

Top module: `ptw_walker`

## Requirements
- R1: After reset, `req_ready` is high while `rsp_valid` and `mem_req_valid` are low. `req_ready` is high only when no walk is in progress. Each accepted request yields exactly one `rsp_valid` pulse lasting one cycle, with `rsp_fault` and `rsp_paddr` valid in that cycle.
- R2: If bits 63 down to 38 of the virtual address are not all equal, the walk faults without any memory access. An address whose bits 63..38 are all ones is walked normally.
- R3: The walk starts at the top of three levels and indexes with VA[38:30], then VA[29:21], then VA[20:12]. Each entry is read at table base + 8 × index, and the table base is the page number shifted left by 12. An entry with V (bit 0) = 1 and R (bit 1), W (bit 2) and X (bit 3) all 0 is a pointer. Its page number field, bits 53:10, gives the base of the next table. A request held off by `mem_req_ready` keeps its address stable.
- R4: An entry with V = 0 faults. A pointer read at the lowest level also faults.
- R5: With U (bit 4) = 1, a supervisor access faults when the supervisor-user-block input is 1. With U = 0, a user access faults.
- R6: A leaf with W = 1 and R = 0 faults for every access type, even a store.
- R7: Access type is encoded 0 = fetch, 1 = load, 2 = store. A fetch needs X. A load needs R, or needs X when the make-executable-readable input is 1. A store needs both R and W.
- R8: On a permitted leaf, the entry is written back with A (bit 6) set, plus D (bit 7) for a store. The write is skipped when the needed flags are already set. When a write is issued, the response waits until the write is acknowledged on `mem_rsp_valid`. A faulting walk writes nothing.
- R9: The physical address is {page number, VA[11:0]}. For a leaf at level L (2 = top, 0 = bottom), the page number is the leaf's page number ORed with the low 9 × L bits of the virtual page number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_vaddr | input | 64 | Virtual address |
| req_type | input | 2 | Access type: 0 fetch, 1 load, 2 store |
| req_smode | input | 1 | 1 = supervisor, 0 = user effective privilege |
| req_pum | input | 1 | Block supervisor access to user pages |
| req_mxr | input | 1 | Let loads read execute-only pages |
| req_root_ppn | input | 44 | Page number of the top-level table |
| mem_req_valid | output | 1 | Memory access request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = write entry back, 0 = read entry |
| mem_req_addr | output | 56 | Byte address of the entry |
| mem_req_wdata | output | 64 | Entry value to write |
| mem_rsp_valid | input | 1 | Read data or write acknowledge |
| mem_rsp_rdata | input | 64 | Entry read data |
| rsp_valid | output | 1 | One-cycle translation result |
| rsp_fault | output | 1 | Page fault |
| rsp_paddr | output | 56 | Physical address (zero on fault) |

## Verification
The assertions watch several rules on every cycle: a single walk in flight, one-cycle responses, held memory requests keeping a stable address, entry addresses being 8-byte aligned, and every write-back carrying V and A. They also check that a non-canonical address faults in the cycle after acceptance, and that the reserved and wrong-owner encodings never pass the leaf check. The checks of leaf decoding order, the effect of the make-executable-readable bit, large-page address composition, and whether the A/D write is issued or skipped depend on table contents. Only the bench scenarios can show these, by reading memory and counting accesses.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2
    } acc_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_RDW,
        ST_WR,
        ST_WRW,
        ST_DONE
    } st_t;

    localparam int B_V = 0;
    localparam int B_R = 1;
    localparam int B_W = 2;
    localparam int B_X = 3;
    localparam int B_U = 4;
    localparam int B_A = 6;
    localparam int B_D = 7;
    localparam int PPN_LSB = 10;
endpackage

// File: rtl/ptw_canon.sv
module ptw_canon #(
    parameter int XLEN    = 64,
    parameter int VA_BITS = 39
) (
    input  logic [XLEN-1:0] vaddr,
    output logic            ok
);
    localparam int TOP_W = XLEN - VA_BITS + 1;

    logic [TOP_W-1:0] top;

    always_comb begin
        top = vaddr[XLEN-1:VA_BITS-1];
        ok  = (&top) | ~(|top);
    end
endmodule

// File: rtl/ptw_perm.sv
module ptw_perm
    import ptw_pkg::*;
(
    input  logic en,
    input  logic r,
    input  logic w,
    input  logic x,
    input  logic u,
    input  acc_t acc,
    input  logic smode,
    input  logic pum,
    input  logic mxr,
    output logic allow
);
    always_comb begin
        // ordered chain: ownership, reserved encoding, access rule
        if (u ? (smode && pum) : !smode) begin
            allow = 1'b0;
        end else if (w && !r) begin
            allow = 1'b0;
        end else begin
            unique case (acc)
                ACC_FETCH: allow = x;
                ACC_LOAD:  allow = r || (mxr && x);
                ACC_STORE: allow = r && w;
                default:   allow = 1'b0;
            endcase
        end
    end

    always_comb begin
        if (en && w && !r) begin
            p_reserved_denied_r6: assert (!allow);
        end
        if (en && !smode && !u) begin
            p_user_needs_u_r5: assert (!allow);
        end
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int XLEN      = 64,
    parameter int LEVELS    = 3,
    parameter int IDX_W     = 9,
    parameter int PG_SHIFT  = 12,
    parameter int PTE_BYTES = 8,
    parameter int PPN_W     = 44
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [XLEN-1:0]           req_vaddr,
    input  logic [1:0]                req_type,
    input  logic                      req_smode,
    input  logic                      req_pum,
    input  logic                      req_mxr,
    input  logic [PPN_W-1:0]          req_root_ppn,
    output logic                      mem_req_valid,
    input  logic                      mem_req_ready,
    output logic                      mem_req_we,
    output logic [PPN_W+PG_SHIFT-1:0] mem_req_addr,
    output logic [8*PTE_BYTES-1:0]    mem_req_wdata,
    input  logic                      mem_rsp_valid,
    input  logic [8*PTE_BYTES-1:0]    mem_rsp_rdata,
    output logic                      rsp_valid,
    output logic                      rsp_fault,
    output logic [PPN_W+PG_SHIFT-1:0] rsp_paddr
);
    localparam int VA_BITS   = PG_SHIFT + LEVELS * IDX_W;
    localparam int PA_W      = PPN_W + PG_SHIFT;
    localparam int PTE_W     = 8 * PTE_BYTES;
    localparam int PTE_SHIFT = $clog2(PTE_BYTES);
    localparam int LVL_W     = (LEVELS > 1) ? $clog2(LEVELS) : 1;
    localparam int VPN_W     = LEVELS * IDX_W;

    typedef struct packed {
        st_t                st;
        logic [LVL_W-1:0]   level;
        logic [PPN_W-1:0]   base;
        logic [VA_BITS-1:0] vaddr;
        acc_t               acc;
        logic               smode;
        logic               pum;
        logic               mxr;
        logic [PTE_W-1:0]   pte;
        logic               fault;
        logic [PA_W-1:0]    paddr;
    } regs_t;

    regs_t q, d;

    logic             canon_ok;
    logic             perm_ok;
    logic             pte_v, pte_ptr, pte_leaf;
    logic [PPN_W-1:0] pte_ppn, lowmask, vpn_ext, ppn_out;
    logic [IDX_W-1:0] idx;
    logic [PA_W-1:0]  pte_addr;
    logic             need_wr;

    ptw_canon #(.XLEN(XLEN), .VA_BITS(VA_BITS)) u_canon (
        .vaddr (req_vaddr),
        .ok    (canon_ok)
    );

    ptw_perm u_perm (
        .en    (q.st == ST_RDW && mem_rsp_valid && pte_leaf),
        .r     (mem_rsp_rdata[B_R]),
        .w     (mem_rsp_rdata[B_W]),
        .x     (mem_rsp_rdata[B_X]),
        .u     (mem_rsp_rdata[B_U]),
        .acc   (q.acc),
        .smode (q.smode),
        .pum   (q.pum),
        .mxr   (q.mxr),
        .allow (perm_ok)
    );

    always_comb begin
        pte_v    = mem_rsp_rdata[B_V];
        pte_ptr  = pte_v && !mem_rsp_rdata[B_R] && !mem_rsp_rdata[B_W] && !mem_rsp_rdata[B_X];
        pte_leaf = pte_v && !pte_ptr;
        pte_ppn  = mem_rsp_rdata[PPN_LSB +: PPN_W];
        idx      = q.vaddr[PG_SHIFT + q.level * IDX_W +: IDX_W];
        pte_addr = {q.base, {PG_SHIFT{1'b0}}} + (PA_W'(idx) << PTE_SHIFT);
        vpn_ext  = PPN_W'(q.vaddr[PG_SHIFT +: VPN_W]);
        lowmask  = ~({PPN_W{1'b1}} << (q.level * IDX_W));
        ppn_out  = pte_ppn | (vpn_ext & lowmask);
        need_wr  = !mem_rsp_rdata[B_A] || (q.acc == ACC_STORE && !mem_rsp_rdata[B_D]);

        d             = q;
        req_ready     = 1'b0;
        mem_req_valid = 1'b0;
        mem_req_we    = 1'b0;
        rsp_valid     = 1'b0;

        unique case (q.st)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    d.vaddr = req_vaddr[VA_BITS-1:0];
                    d.acc   = acc_t'(req_type);
                    d.smode = req_smode;
                    d.pum   = req_pum;
                    d.mxr   = req_mxr;
                    d.base  = req_root_ppn;
                    d.level = LVL_W'(LEVELS - 1);
                    d.paddr = '0;
                    d.fault = !canon_ok;
                    d.st    = canon_ok ? ST_RD : ST_DONE;
                end
            end
            ST_RD: begin
                mem_req_valid = 1'b1;
                if (mem_req_ready) d.st = ST_RDW;
            end
            ST_RDW: begin
                if (mem_rsp_valid) begin
                    if (!pte_v) begin
                        d.fault = 1'b1;
                        d.st    = ST_DONE;
                    end else if (pte_ptr) begin
                        if (q.level == '0) begin
                            d.fault = 1'b1;
                            d.st    = ST_DONE;
                        end else begin
                            d.base  = pte_ppn;
                            d.level = q.level - 1'b1;
                            d.st    = ST_RD;
                        end
                    end else if (!perm_ok) begin
                        d.fault = 1'b1;
                        d.st    = ST_DONE;
                    end else begin
                        d.paddr      = {ppn_out, q.vaddr[PG_SHIFT-1:0]};
                        d.pte        = mem_rsp_rdata;
                        d.pte[B_A]   = 1'b1;
                        if (q.acc == ACC_STORE) d.pte[B_D] = 1'b1;
                        d.st         = need_wr ? ST_WR : ST_DONE;
                    end
                end
            end
            ST_WR: begin
                mem_req_valid = 1'b1;
                mem_req_we    = 1'b1;
                if (mem_req_ready) d.st = ST_WRW;
            end
            ST_WRW: begin
                if (mem_rsp_valid) d.st = ST_DONE;
            end
            ST_DONE: begin
                rsp_valid = 1'b1;
                d.st      = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.acc   <= ACC_FETCH;
        end else begin
            q <= d;
        end
    end

    assign mem_req_addr  = pte_addr;
    assign mem_req_wdata = q.pte;
    assign rsp_fault     = q.fault;
    assign rsp_paddr     = q.paddr;

    p_busy_after_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    p_rsp_single_cycle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_noncanon_fault_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready
        && !((&req_vaddr[XLEN-1:VA_BITS-1]) || !(|req_vaddr[XLEN-1:VA_BITS-1]))
        |=> rsp_valid && rsp_fault && !mem_req_valid);

    p_mem_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready
        |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we));

    p_pte_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> mem_req_addr[PTE_SHIFT-1:0] == '0);

    p_wb_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_we |-> mem_req_wdata[B_A] && mem_req_wdata[B_V]);
endmodule

// File: tb/tb_ptw_walker.sv
module tb_ptw_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_vaddr = '0;
    logic [1:0]  req_type = '0;
    logic        req_smode = 1'b0;
    logic        req_pum = 1'b0;
    logic        req_mxr = 1'b0;
    logic [43:0] req_root_ppn = 44'h100;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic        mem_req_we;
    logic [55:0] mem_req_addr;
    logic [63:0] mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_rdata = '0;
    logic        rsp_valid;
    logic        rsp_fault;
    logic [55:0] rsp_paddr;

    logic [63:0] mem [logic [55:0]];
    int unsigned cyc = 0;
    int unsigned rd_cnt = 0;
    int unsigned wr_cnt = 0;
    int total = 0;
    int bad = 0;
    bit finished = 0;

    localparam logic [63:0] FV = 64'h01, FR = 64'h02, FW = 64'h04, FX = 64'h08;
    localparam logic [63:0] FU = 64'h10, FA = 64'h40, FD = 64'h80;

    ptw_walker dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_type(req_type), .req_smode(req_smode), .req_pum(req_pum),
        .req_mxr(req_mxr), .req_root_ppn(req_root_ppn),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata), .rsp_valid(rsp_valid),
        .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr)
    );

    always #10 clk = ~clk;

    assign mem_req_ready = (cyc % 3) != 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        mem_rsp_valid <= 1'b0;
        if (mem_req_valid && mem_req_ready) begin
            if (mem_req_we) begin
                mem[mem_req_addr] = mem_req_wdata;
                wr_cnt <= wr_cnt + 1;
            end else begin
                mem_rsp_rdata <= mem.exists(mem_req_addr) ? mem[mem_req_addr] : 64'h0;
                rd_cnt <= rd_cnt + 1;
            end
            mem_rsp_valid <= 1'b1;
        end
    end

    function automatic logic [63:0] mk(input logic [43:0] ppn, input logic [63:0] f);
        return ({20'h0, ppn} << 10) | f;
    endfunction

    function automatic logic [55:0] l0a(input int k);
        return 56'h102000 + 56'(k * 8);
    endfunction

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic walk(input logic [63:0] va, input logic [1:0] ty, input logic s,
                        input logic pum, input logic mxr,
                        output logic flt, output logic [55:0] pa, output int lat);
        @(negedge clk);
        req_vaddr = va; req_type = ty; req_smode = s; req_pum = pum; req_mxr = mxr;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 500) begin
            @(negedge clk);
            lat++;
        end
        flt = rsp_fault;
        pa = rsp_paddr;
        @(negedge clk);
        if (rsp_valid) check("R1", "response longer than one cycle", 1, 0);
    endtask

    task automatic t_reset;
        check("R1", "reset req_ready", req_ready, 1);
        check("R1", "reset rsp_valid", rsp_valid, 0);
        check("R1", "reset mem_req_valid", mem_req_valid, 0);
    endtask

    task automatic t_basic_and_skip;
        logic f; logic [55:0] p; int l; int unsigned w0;
        w0 = wr_cnt;
        walk(64'h123, 2'd1, 1'b0, 1'b0, 1'b0, f, p, l);
        check("R3", "user load fault", f, 0);
        check("R9", "user load paddr", p, 56'h500123);
        walk(64'h7ff, 2'd2, 1'b0, 1'b0, 1'b0, f, p, l);
        check("R7", "user store fault", f, 0);
        check("R9", "user store paddr", p, 56'h5007ff);
        check("R8", "no write when A and D already set", wr_cnt - w0, 0);
    endtask

    task automatic t_ownership;
        logic f; logic [55:0] p; int l;
        walk(64'h10, 2'd1, 1'b1, 1'b1, 1'b0, f, p, l);
        check("R5", "supervisor on user page with block", f, 1);
        walk(64'h10, 2'd1, 1'b1, 1'b0, 1'b0, f, p, l);
        check("R5", "supervisor on user page without block", f, 0);
        walk(64'h5010, 2'd1, 1'b0, 1'b0, 1'b0, f, p, l);
        check("R5", "user on supervisor page", f, 1);
    endtask

    task automatic t_reserved;
        logic f; logic [55:0] p; int l; int unsigned w0;
        w0 = wr_cnt;
        walk(64'h2000, 2'd2, 1'b0, 1'b0, 1'b0, f, p, l);
        check("R6", "write-only store", f, 1);
        walk(64'h2000, 2'd1, 1'b0, 1'b0, 1'b1, f, p, l);
        check("R6", "write-only load", f, 1);
        check("R8", "fault writes nothing", wr_cnt - w0, 0);
    endtask

    task automatic t_exec_only;
        logic f; logic [55:0] p; int l; int unsigned w0;
        w0 = wr_cnt;
        walk(64'h1456, 2'd0, 1'b1, 1'b0, 1'b0, f, p, l);
        check("R7", "fetch exec-only", f, 0);
        check("R9", "fetch paddr", p, 56'h501456);
        check("R8", "A set on fetch", mem[l0a(1)], mk(44'h501, FV | FX | FA));
        check("R8", "one write on fetch", wr_cnt - w0, 1);
        walk(64'h1456, 2'd1, 1'b1, 1'b0, 1'b0, f, p, l);
        check("R7", "load exec-only without mxr", f, 1);
        walk(64'h1456, 2'd1, 1'b1, 1'b0, 1'b1, f, p, l);
        check("R7", "load exec-only with mxr", f, 0);
        walk(64'h1456, 2'd2, 1'b1, 1'b0, 1'b1, f, p, l);
        check("R7", "store exec-only", f, 1);
        check("R8", "no further writes", wr_cnt - w0, 1);
    endtask

    task automatic t_dirty;
        logic f; logic [55:0] p; int l; int unsigned w0;
        w0 = wr_cnt;
        walk(64'h5078, 2'd2, 1'b1, 1'b0, 1'b0, f, p, l);
        check("R8", "supervisor store ok", f, 0);
        check("R9", "supervisor store paddr", p, 56'h505078);
        check("R8", "A and D set", mem[l0a(5)], mk(44'h505, FV | FR | FW | FA | FD));
        walk(64'h5078, 2'd2, 1'b1, 1'b0, 1'b0, f, p, l);
        check("R8", "repeat store no write", wr_cnt - w0, 1);
        walk(64'h6000, 2'd2, 1'b0, 1'b0, 1'b0, f, p, l);
        check("R8", "D-only update", mem[l0a(6)], mk(44'h506, FV | FR | FW | FU | FA | FD));
        check("R8", "D-only write count", wr_cnt - w0, 2);
    endtask

    task automatic t_bad_entries;
        logic f; logic [55:0] p; int l;
        walk(64'h3000, 2'd1, 1'b1, 1'b0, 1'b0, f, p, l);
        check("R4", "pointer at last level", f, 1);
        walk(64'h4000, 2'd1, 1'b1, 1'b0, 1'b0, f, p, l);
        check("R4", "invalid entry", f, 1);
        check("R4", "fault paddr zero", p, 0);
    endtask

    task automatic t_superpages;
        logic f; logic [55:0] p; int l; int unsigned w0;
        w0 = wr_cnt;
        walk(64'h4ABC_DEF0, 2'd2, 1'b1, 1'b0, 1'b0, f, p, l);
        check("R9", "gigapage fault", f, 0);
        check("R9", "gigapage paddr", p, 56'h4ABC_DEF0);
        walk(64'h21_2345, 2'd1, 1'b0, 1'b0, 1'b0, f, p, l);
        check("R9", "megapage fault", f, 0);
        check("R9", "megapage paddr", p, 56'h61_2345);
        check("R8", "load with A set no write", wr_cnt - w0, 0);
    endtask

    task automatic t_canonical;
        logic f; logic [55:0] p; int l; int unsigned r0;
        r0 = rd_cnt;
        walk(64'h0000_0040_0000_0000, 2'd1, 1'b1, 1'b0, 1'b0, f, p, l);
        check("R2", "non-canonical fault", f, 1);
        check("R2", "non-canonical no reads", rd_cnt - r0, 0);
        walk(64'hFFFF_FFC0_0000_0000, 2'd1, 1'b1, 1'b0, 1'b0, f, p, l);
        check("R2", "high canonical walked", rd_cnt - r0, 1);
        check("R4", "high canonical absent entry", f, 1);
    endtask

    initial begin
        mem[56'h100000] = mk(44'h101, FV);
        mem[56'h100008] = mk(44'h40000, FV | FR | FW | FX | FA | FD);
        mem[56'h101000] = mk(44'h102, FV);
        mem[56'h101008] = mk(44'h600, FV | FR | FU | FA);
        mem[l0a(0)] = mk(44'h500, FV | FR | FW | FU | FA | FD);
        mem[l0a(1)] = mk(44'h501, FV | FX);
        mem[l0a(2)] = mk(44'h502, FV | FW | FU);
        mem[l0a(3)] = mk(44'h503, FV);
        mem[l0a(5)] = mk(44'h505, FV | FR | FW);
        mem[l0a(6)] = mk(44'h506, FV | FR | FW | FU | FA);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_basic_and_skip;
        t_ownership;
        t_reserved;
        t_exec_only;
        t_dirty;
        t_bad_entries;
        t_superpages;
        t_canonical;
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule